// File: doc/BRIEF.md
# Two-Stage Divider Setting Solver

This block turns a requested clock rate into settings for a two-stage divider chain: a pre-divider of 1 to 32 followed by a post-divider of 1 to 4. It takes a 32-bit requested rate, a 32-bit parent rate and a 2-bit source index. It returns the two register codes, the rate the chain would actually produce, and flags for error and saturation. A one-cycle `start` launches a solve, `busy` stays high while it runs, and `done` pulses once when every output is valid. Outputs hold their values until the next accepted start.

The solve runs in a fixed order. First the request is clamped to the parent rate. Then the overall ratio is the ceiling of parent over request. Source 3 alone may spread that ratio across both stages using fixed ratio bands; every other source uses the post-divider only. Finally the achieved rate is computed by dividing the parent rate by each stage in turn. All three divisions share one restoring divider that takes one cycle per quotient bit.

The controller has six states:
- `ST_IDLE` waits for `start`.
- `ST_RATIO` waits for the ratio division.
- `ST_SPLIT` picks the stage values and launches the first rate division.
- `ST_PRE` waits for the division by the pre-divider.
- `ST_POST` waits for the division by the post-divider.
- `ST_DONE` raises `done` for one cycle.

The transitions are:
- IDLE→RATIO on a start with a nonzero request.
- IDLE→DONE on a start with a zero request.
- RATIO→SPLIT, PRE→POST and POST→DONE on divider completion.
- SPLIT→PRE unconditionally.
- DONE→IDLE unconditionally.

Top module: `ratio_split_solver`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `sat` are 0, and `pre_code`, `post_code` and `achieved` are 0.
- R2: A `start` seen while `busy` is low is accepted, and `busy` is high from the next cycle. With a nonzero request, `done` is high for exactly one cycle, 3*W+8 clock edges after the accepting edge (104 with W=32), counting that edge as the first. With a zero request, `done` is high right after the accepting edge. `busy` falls the cycle after `done`.
- R3: A requested rate of 0 sets `err` and clears `sat`, and gives `pre_code` = 0, `post_code` = 0 and `achieved` = 0.
- R4: When the parent rate is nonzero and the request exceeds it, the request is replaced by the parent rate, which gives an overall ratio of 1.
- R5: The overall ratio is ceil(parent/request). A parent rate of 0 gives a ratio of 1 and an achieved rate of 0.
- R6: For source indexes 0, 1 and 2, the pre-divider is 1 (`pre_code` = 0) and the post-divider equals the ratio. Each code is its stage value minus one: `pre_code` is 5 bits, `post_code` is 2 bits.
- R7: For source indexes 0 to 2, a ratio above 4 sets the post-divider to 4 (`post_code` = 3) and sets `sat`.
- R8: For source index 3, a ratio of 4 or less behaves as in R6, with `sat` = 0.
- R9: For source index 3, a ratio of 5 to 31 gives pre-divider = ratio and post-divider = 1.
- R10: For source index 3, the post-divider depends on the ratio band:
  - 32 to 63: post-divider 2;
  - 64 to 95: post-divider 3;
  - 96 and above: post-divider 4.

  In each band the pre-divider is ceil(ratio/post-divider).
- R11: For source index 3, a pre-divider above 32 is forced to 32 (`pre_code` = 31) and `sat` is set.
- R12: `achieved` = floor(floor(parent/pre-divider)/post-divider), using the stage values after any saturation.
- R13: A `start` while `busy` is high is ignored: the running solve keeps its timing and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a solve (taken only when idle) |
| req_rate | input | W | Requested output rate |
| par_rate | input | W | Parent rate |
| src_sel | input | SRC_W | Source index; value 3 enables the two-stage split |
| busy | output | 1 | Solve in progress (includes the done cycle) |
| done | output | 1 | One-cycle pulse: outputs valid |
| err | output | 1 | Request was zero |
| sat | output | 1 | A stage value was saturated |
| pre_code | output | 5 | Pre-divider minus one |
| post_code | output | 2 | Post-divider minus one |
| achieved | output | W | Rate produced by the chosen settings |

## Verification
Some properties are checked on every cycle:
- `done` is a single-cycle pulse.
- An accepted start raises `busy`.
- An error result carries all-zero settings.
- A non-split source always reports a pre-divider of 1.
- The achieved rate never exceeds the parent rate.
- Without saturation, the achieved rate never exceeds the clamped request.

Only the bench's scenarios can show the rest. These are the exact band edges at ratios 31/32, 63/64 and 95/96, the ceiling rounding inside each band, saturation at extreme ratios, the fixed latency, and that a start during a solve leaves the running result untouched.

// File: rtl/split_pkg.sv
package split_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RATIO,
        ST_SPLIT,
        ST_PRE,
        ST_POST,
        ST_DONE
    } solver_state_e;
endpackage

// File: rtl/restoring_div.sv
module restoring_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         fin,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  dvs;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted;
    logic [W:0]    diff;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvs};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvs <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
            quo <= '0;
            rem <= '0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem <= '0;
                quo <= dividend;
                dvs <= divisor;
                cnt <= CW'(W);
                run <= 1'b1;
            end else if (run) begin
                if (!diff[W]) begin
                    rem <= diff[W-1:0];
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shifted[W-1:0];
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ratio_splitter.sv
module ratio_splitter #(
    parameter int W        = 32,
    parameter int PRE_MAX  = 32,
    parameter int POST_MAX = 4
) (
    input  logic         split_en,
    input  logic [W-1:0] ratio,
    output logic [W-1:0] pre,
    output logic [W-1:0] post,
    output logic         sat
);
    localparam int WX = W + 1;

    logic        picked;
    logic [W:0]  wide;

    always_comb begin
        wide   = {1'b0, ratio};
        picked = 1'b0;
        pre    = W'(1);
        post   = ratio;
        sat    = 1'b0;
        if (split_en && ratio > W'(POST_MAX)) begin
            for (int j = 1; j < POST_MAX; j++) begin
                if (!picked && ratio < W'(PRE_MAX * j)) begin
                    picked = 1'b1;
                    post   = W'(j);
                    pre    = W'((wide + WX'(j - 1)) / WX'(j));
                end
            end
            if (!picked) begin
                post = W'(POST_MAX);
                pre  = W'((wide + WX'(POST_MAX - 1)) / WX'(POST_MAX));
            end
            if (pre > W'(PRE_MAX)) begin
                pre = W'(PRE_MAX);
                sat = 1'b1;
            end
        end else if (ratio > W'(POST_MAX)) begin
            post = W'(POST_MAX);
            sat  = 1'b1;
        end
    end
endmodule

// File: rtl/ratio_split_solver.sv
module ratio_split_solver
    import split_pkg::*;
#(
    parameter int W         = 32,
    parameter int SRC_W     = 2,
    parameter int SPLIT_SRC = 3,
    parameter int PRE_MAX   = 32,
    parameter int POST_MAX  = 4,
    localparam int PRE_CW   = $clog2(PRE_MAX),
    localparam int POST_CW  = $clog2(POST_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [W-1:0]       req_rate,
    input  logic [W-1:0]       par_rate,
    input  logic [SRC_W-1:0]   src_sel,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               sat,
    output logic [PRE_CW-1:0]  pre_code,
    output logic [POST_CW-1:0] post_code,
    output logic [W-1:0]       achieved
);
    solver_state_e state, nxt;

    logic [W-1:0]     par_q, ratio_q, post_q;
    logic [SRC_W-1:0] src_q;
    logic             dv_go, dv_fin;
    logic [W-1:0]     dv_a, dv_b, dv_q, dv_r;
    logic [W-1:0]     req_cl, ratio_n;
    logic [W-1:0]     sp_pre, sp_post;
    logic             sp_sat;

    restoring_div #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(dv_go),
        .dividend(dv_a), .divisor(dv_b),
        .fin(dv_fin), .quo(dv_q), .rem(dv_r)
    );

    ratio_splitter #(.W(W), .PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX)) u_split (
        .split_en(src_q == SRC_W'(SPLIT_SRC)), .ratio(ratio_q),
        .pre(sp_pre), .post(sp_post), .sat(sp_sat)
    );

    always_comb begin
        req_cl  = (par_rate != '0 && req_rate > par_rate) ? par_rate : req_rate;
        ratio_n = dv_q + {{(W-1){1'b0}}, (dv_r != '0)};
        if (ratio_n == '0) ratio_n = W'(1);
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = (req_rate == '0) ? ST_DONE : ST_RATIO;
            ST_RATIO: if (dv_fin) nxt = ST_SPLIT;
            ST_SPLIT: nxt = ST_PRE;
            ST_PRE:   if (dv_fin) nxt = ST_POST;
            ST_POST:  if (dv_fin) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q     <= '0;
            ratio_q   <= '0;
            post_q    <= '0;
            src_q     <= '0;
            dv_go     <= 1'b0;
            dv_a      <= '0;
            dv_b      <= '0;
            err       <= 1'b0;
            sat       <= 1'b0;
            pre_code  <= '0;
            post_code <= '0;
            achieved  <= '0;
        end else begin
            dv_go <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    err   <= (req_rate == '0);
                    sat   <= 1'b0;
                    par_q <= par_rate;
                    src_q <= src_sel;
                    if (req_rate == '0) begin
                        pre_code  <= '0;
                        post_code <= '0;
                        achieved  <= '0;
                    end else begin
                        dv_go <= 1'b1;
                        dv_a  <= par_rate;
                        dv_b  <= req_cl;
                    end
                end
                ST_RATIO: if (dv_fin) ratio_q <= ratio_n;
                ST_SPLIT: begin
                    post_q    <= sp_post;
                    sat       <= sp_sat;
                    pre_code  <= PRE_CW'(sp_pre - W'(1));
                    post_code <= POST_CW'(sp_post - W'(1));
                    dv_go     <= 1'b1;
                    dv_a      <= par_q;
                    dv_b      <= sp_pre;
                end
                ST_PRE: if (dv_fin) begin
                    dv_go <= 1'b1;
                    dv_a  <= dv_q;
                    dv_b  <= post_q;
                end
                ST_POST: if (dv_fin) achieved <= dv_q;
                ST_DONE: ;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/split_solver_chk.sv
module split_solver_chk #(
    parameter int W         = 32,
    parameter int SRC_W     = 2,
    parameter int SPLIT_SRC = 3,
    parameter int PRE_CW    = 5,
    parameter int POST_CW   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [W-1:0]       req_rate,
    input logic [W-1:0]       par_rate,
    input logic [SRC_W-1:0]   src_sel,
    input logic               busy,
    input logic               done,
    input logic               err,
    input logic               sat,
    input logic [PRE_CW-1:0]  pre_code,
    input logic [POST_CW-1:0] post_code,
    input logic [W-1:0]       achieved
);
    logic [W-1:0]     cap_par, cap_req;
    logic [SRC_W-1:0] cap_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_par <= '0;
            cap_req <= '0;
            cap_src <= '0;
        end else if (start && !busy) begin
            cap_par <= par_rate;
            cap_req <= (par_rate != '0 && req_rate > par_rate) ? par_rate : req_rate;
            cap_src <= src_sel;
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R3
    zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (pre_code == '0 && post_code == '0 && achieved == '0 && !sat));

    // R6
    other_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && cap_src != SRC_W'(SPLIT_SRC)) |-> (pre_code == '0));

    // R12
    ach_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (achieved <= cap_par));

    // R4
    ach_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !sat) |-> (achieved <= cap_req));
endmodule

bind ratio_split_solver split_solver_chk #(
    .W(W), .SRC_W(SRC_W), .SPLIT_SRC(SPLIT_SRC), .PRE_CW(PRE_CW), .POST_CW(POST_CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
    .par_rate(par_rate), .src_sel(src_sel), .busy(busy), .done(done),
    .err(err), .sat(sat), .pre_code(pre_code), .post_code(post_code),
    .achieved(achieved)
);

// File: tb/test_ratio_split_solver.sv
module test_ratio_split_solver;
    localparam int W   = 32;
    localparam int LAT = 3 * W + 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_rate = '0;
    logic [31:0] par_rate = '0;
    logic [1:0]  src_sel = '0;
    logic        busy, done, err, sat;
    logic [4:0]  pre_code;
    logic [1:0]  post_code;
    logic [31:0] achieved;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    ratio_split_solver i_ratio_split_solver (
        .clk(clk), .rst_n(rst_n), .start(start), .req_rate(req_rate),
        .par_rate(par_rate), .src_sel(src_sel), .busy(busy), .done(done),
        .err(err), .sat(sat), .pre_code(pre_code), .post_code(post_code),
        .achieved(achieved)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model(input longint rq, input longint pr, input int sc,
                         output bit e, output bit s, output longint pre,
                         output longint post, output longint ach);
        longint r, ratio;
        e = 0; s = 0; pre = 1; post = 1; ach = 0;
        if (rq == 0) begin
            e = 1; pre = 1; post = 1; ach = 0;
            return;
        end
        r = rq;
        if (pr != 0 && r > pr) r = pr;
        ratio = (pr + r - 1) / r;
        if (ratio == 0) ratio = 1;
        if (sc == 3 && ratio > 4) begin
            if (ratio < 32)      post = 1;
            else if (ratio < 64) post = 2;
            else if (ratio < 96) post = 3;
            else                 post = 4;
            pre = (ratio + post - 1) / post;
            if (pre > 32) begin pre = 32; s = 1; end
        end else begin
            pre = 1; post = ratio;
            if (post > 4) begin post = 4; s = 1; end
        end
        ach = (pr / pre) / post;
    endtask

    task automatic run(input longint rq, input longint pr, input int sc,
                       input string tag, input bit poke);
        bit e, s;
        longint pre, post, ach;
        int lat;
        model(rq, pr, sc, e, s, pre, post, ach);
        lat = e ? 1 : LAT;
        @(negedge clk);
        start = 1'b1; req_rate = 32'(rq); par_rate = 32'(pr); src_sel = 2'(sc);
        for (int k = 1; k <= lat + 1; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 10) begin
                start = 1'b1; req_rate = 32'd7; par_rate = 32'd700; src_sel = 2'd0;
            end
            if (poke && k == 11) start = 1'b0;
            chk(busy == (k <= lat), "R2", $sformatf("%s busy k=%0d", tag, k), busy, (k <= lat));
            chk(done == (k == lat), "R2", $sformatf("%s done k=%0d", tag, k), done, (k == lat));
            if (k == lat) begin
                chk(err == e, tag, "err", err, e);
                chk(sat == s, tag, "sat", sat, s);
                chk(pre_code == (e ? 0 : pre - 1), tag, "pre_code", pre_code, e ? 0 : pre - 1);
                chk(post_code == (e ? 0 : post - 1), tag, "post_code", post_code, e ? 0 : post - 1);
                chk(achieved == ach, tag, "achieved", achieved, ach);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !err && !sat, "R1", "flags", {busy, done, err, sat}, 0);
        chk(pre_code == 0 && post_code == 0 && achieved == 0, "R1", "outputs", achieved, 0);

        run(0, 1000, 3, "R3 zero request", 0);
        run(30, 100, 0, "R6 R5 ceiling", 0);
        run(50, 100, 1, "R6 ratio 2", 0);
        run(10, 1000, 2, "R7 saturate post", 0);
        run(80, 50, 0, "R4 clamp", 0);
        run(80, 50, 3, "R4 clamp src3", 0);
        run(5, 0, 0, "R5 zero parent", 0);
        run(25, 100, 3, "R8 src3 ratio 4", 0);
        run(1000000, 24000000, 3, "R9 ratio 24", 0);
        run(1, 31, 3, "R9 ratio 31", 0);
        run(1, 32, 3, "R10 ratio 32", 0);
        run(500000, 24000000, 3, "R10 ratio 48", 0);
        run(1, 63, 3, "R10 ratio 63", 0);
        run(1, 64, 3, "R10 ratio 64", 0);
        run(300000, 24000000, 3, "R10 ratio 80", 0);
        run(1, 95, 3, "R10 ratio 95", 0);
        run(1, 96, 3, "R10 ratio 96", 0);
        run(200000, 24000000, 3, "R10 ratio 120", 0);
        run(1, 128, 3, "R10 ratio 128", 0);
        run(1, 129, 3, "R11 ratio 129", 0);
        run(100000, 24000000, 3, "R11 ratio 240", 0);
        run(1, 64'hFFFFFFFF, 3, "R11 R12 extreme", 0);
        run(7, 1000, 1, "R12 floor", 0);
        run(3, 1000, 3, "R13 start while busy", 1);
        run(7, 700, 0, "R13 follow-up", 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule